// File: doc/BRIEF.md
# Partial-Word Store Lane Unit

This unit turns a partial-word store request into one write beat on a big-endian, word-wide memory port. The request carries an operation kind, a byte address and a source word. A *head* store writes the low-order bytes of the source. It starts at the addressed byte and runs to the last byte of the word. A *tail* store writes the high-order bytes of the source into the bytes of the word that lie before the addressed byte. Lane 0 is the most significant byte of the word.

Each source byte keeps its bit position in the word, so the data never has to be shifted. The unit only chooses which lanes to enable and clears the lanes it does not enable. Every request gives exactly one beat, so the three-byte cases are a single masked write and stay atomic. A tail store at offset 0 writes nothing. It still sends a beat, with all lane enables low and the probe flag set, so that the memory side checks write permission and marks the line dirty. The request side and the write side each use a valid/ready handshake. A one-entry output register sits between them.

Top module: `psb_store_lanes`

## Requirements
- R1: While reset is asserted and after it is released with no request, wr_valid_o is 0 and req_ready_o is 1.
- R2: A head store (req_op_i = 0) with byte offset k = address mod 4 enables lanes k through 3. The enable is 4'b1111, 4'b0111, 4'b0011 or 4'b0001 for k = 0, 1, 2, 3 (enable bit 3 is lane 0, the most significant byte).
- R3: A tail store (req_op_i = 1) with offset k enables lanes 0 through k-1. The enable is 4'b1000, 4'b1100 or 4'b1110 for k = 1, 2, 3.
- R4: Each accepted request produces exactly one write beat, including the three-byte cases (head k = 1 with mask 0x00FFFFFF, tail k = 3 with mask 0xFFFFFF00).
- R5: A tail store at offset 0 produces a beat with wr_be_o = 4'b0000 and wr_probe_o = 1. Every other beat has wr_probe_o = 0 and a nonzero enable.
- R6: An enabled lane carries the source byte that sits in the same bit position (lane j carries data bits 31-8j down to 24-8j). Disabled lanes are driven to zero.
- R7: wr_addr_o equals the request address with its two low bits cleared.
- R8: While wr_valid_o is 1 and wr_ready_i is 0, the beat (address, enable, data, probe) stays unchanged on the next cycle.
- R9: req_ready_o is 1 exactly when the output register is empty or is being drained in that cycle (not wr_valid_o, or wr_ready_i). A beat appears one cycle after its request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Store request valid |
| req_ready_o | output | 1 | Store request accepted when high with valid |
| req_op_i | input | 1 | 0 = head store, 1 = tail store |
| req_addr_i | input | 32 | Byte address |
| req_data_i | input | 32 | Source word |
| wr_valid_o | output | 1 | Write beat valid |
| wr_ready_i | input | 1 | Write beat accepted |
| wr_addr_o | output | 32 | Word-aligned address |
| wr_be_o | output | 4 | Lane enables, bit 3 = lane 0 |
| wr_data_o | output | 32 | Lane-aligned write data |
| wr_probe_o | output | 1 | Protection probe flag for the zero-length tail case |

## Verification
The bench builds the unit with its default 32-bit address and 32-bit data, which gives four lanes and covers all eight pairs of operation and offset. It runs those pairs with several data patterns across different words. The write side is stalled by a pseudo-random ready signal, which exercises holding the beat, draining the register and accepting a new request in the same cycle. A byte-array model of memory is built from the requirement rules and compared with the memory the beats produce, so the unwritten bytes around each partial store are checked as well.

// File: rtl/psb_pkg.sv
package psb_pkg;
  typedef enum logic {
    PSB_HEAD = 1'b0,
    PSB_TAIL = 1'b1
  } psb_op_e;
endpackage

// File: rtl/psb_lane_mask.sv
module psb_lane_mask
  import psb_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input  psb_op_e            op_i,
  input  logic [OFF_W-1:0]   off_i,
  output logic [LANES-1:0]   be_o,
  output logic               probe_o
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic head_en, tail_en;
    assign head_en = (OFF_W'(j) >= off_i);
    assign tail_en = (OFF_W'(j) <  off_i);
    // lane 0 maps to the top enable bit
    assign be_o[LANES-1-j] = (op_i == PSB_HEAD) ? head_en : tail_en;
  end

  assign probe_o = (op_i == PSB_TAIL) && (off_i == '0);
endmodule

// File: rtl/psb_lane_data.sv
module psb_lane_data #(
  parameter int unsigned LANES = 4,
  localparam int unsigned DATA_W = LANES * 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [LANES-1:0]  be_i,
  output logic [DATA_W-1:0] data_o
);
  for (genvar b = 0; b < LANES; b++) begin : g_byte
    assign data_o[b*8 +: 8] = be_i[b] ? data_i[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/psb_beat_reg.sv
module psb_beat_reg #(
  parameter int unsigned PAYLOAD_W = 69
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [PAYLOAD_W-1:0] in_payload_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [PAYLOAD_W-1:0] out_payload_o
);
  logic                 valid_q;
  logic [PAYLOAD_W-1:0] payload_q;

  assign in_ready_o    = !valid_q || out_ready_i;
  assign out_valid_o   = valid_q;
  assign out_payload_o = payload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      payload_q <= '0;
    end else if (in_valid_i && in_ready_o) begin
      valid_q   <= 1'b1;
      payload_q <= in_payload_i;
    end else if (out_ready_i) begin
      valid_q   <= 1'b0;
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_payload_o)));

  // R9
  accept_to_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (out_valid_o && out_payload_o == $past(in_payload_i)));
endmodule

// File: rtl/psb_store_lanes.sv
module psb_store_lanes
  import psb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES  = DATA_W / 8,
  localparam int unsigned OFF_W  = $clog2(LANES),
  localparam int unsigned PAYLOAD_W = 1 + ADDR_W + LANES + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [LANES-1:0]  wr_be_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_probe_o
);
  psb_op_e           op;
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] word_addr;
  logic [LANES-1:0]  be_d;
  logic              probe_d;
  logic [DATA_W-1:0] data_d;
  logic [PAYLOAD_W-1:0] payload_d, payload_q;

  assign op        = psb_op_e'(req_op_i);
  assign off       = req_addr_i[OFF_W-1:0];
  assign word_addr = {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  psb_lane_mask #(.LANES(LANES)) u_mask (
    .op_i    (op),
    .off_i   (off),
    .be_o    (be_d),
    .probe_o (probe_d)
  );

  psb_lane_data #(.LANES(LANES)) u_data (
    .data_i (req_data_i),
    .be_i   (be_d),
    .data_o (data_d)
  );

  assign payload_d = {probe_d, word_addr, be_d, data_d};

  psb_beat_reg #(.PAYLOAD_W(PAYLOAD_W)) u_beat (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .in_valid_i    (req_valid_i),
    .in_ready_o    (req_ready_o),
    .in_payload_i  (payload_d),
    .out_valid_o   (wr_valid_o),
    .out_ready_i   (wr_ready_i),
    .out_payload_o (payload_q)
  );

  assign {wr_probe_o, wr_addr_o, wr_be_o, wr_data_o} = payload_q;

  // R5
  probe_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (wr_probe_o == (wr_be_o == '0)));

  // R7
  addr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=>
      (wr_addr_o[ADDR_W-1:OFF_W] == $past(req_addr_i[ADDR_W-1:OFF_W]) && wr_addr_o[OFF_W-1:0] == '0));

  // R2
  head_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !req_op_i && req_addr_i[OFF_W-1:0] == '0) |=> (wr_be_o == '1));

  // R1
  idle_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_o |-> req_ready_o);
endmodule

// File: tb/psb_store_lanes_test.sv
module psb_store_lanes_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LANES  = 4;
  localparam int MEM_B  = 64;

  logic clk = 0, rst_ni = 0;
  logic req_valid_i = 0, req_op_i = 0, wr_ready_i = 0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [DATA_W-1:0] req_data_i = '0;
  logic req_ready_o, wr_valid_o, wr_probe_o;
  logic [ADDR_W-1:0] wr_addr_o;
  logic [LANES-1:0]  wr_be_o;
  logic [DATA_W-1:0] wr_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  psb_store_lanes uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_op_i(req_op_i), .req_addr_i(req_addr_i), .req_data_i(req_data_i),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_addr_o(wr_addr_o), .wr_be_o(wr_be_o), .wr_data_o(wr_data_o),
    .wr_probe_o(wr_probe_o)
  );

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  be;
    logic [DATA_W-1:0] data;
    logic              probe;
  } beat_t;

  beat_t exp_q[$];
  logic [7:0] ref_mem [MEM_B];
  logic [7:0] dut_mem [MEM_B];
  int checks = 0, fails = 0, sent = 0, beats = 0;
  bit finished = 0;
  bit full_ready = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: builds the expected beat from the requirement rules and pushes it on acceptance
  task automatic send(input bit op, input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] data);
    beat_t e;
    int k;
    bit acc;
    k = int'(addr[1:0]);
    e.addr = {addr[ADDR_W-1:2], 2'b00};
    e.be = '0;
    e.data = '0;
    for (int j = 0; j < LANES; j++) begin
      bit en;
      en = op ? (j < k) : (j >= k);  // R2 head: lanes k..3, R3 tail: lanes 0..k-1
      if (en) begin
        e.be[LANES-1-j] = 1'b1;
        e.data[DATA_W-1-8*j -: 8] = data[DATA_W-1-8*j -: 8];  // R6
        ref_mem[(int'(addr) & (MEM_B-4)) + j] = data[DATA_W-1-8*j -: 8];
      end
    end
    e.probe = op && (k == 0);  // R5
    @(negedge clk);
    req_valid_i = 1; req_op_i = op; req_addr_i = addr; req_data_i = data;
    forever begin
      #(CLK_PERIOD/2 - 1);
      acc = req_ready_o;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    exp_q.push_back(e);
    sent++;
    #1 req_valid_i = 0;
  endtask

  // Write-side ready: pseudo-random back-pressure
  initial forever begin
    @(posedge clk);
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready_i = full_ready ? 1'b1 : lfsr[0];
  end

  // Monitor: samples just before each rising edge
  initial begin
    beat_t last;
    bit hold_pend;
    hold_pend = 0;
    last = '0;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/2 - 1);
      if (rst_ni) begin
        check(req_ready_o == (!wr_valid_o || wr_ready_i), "R9", "ready rule",
              64'(req_ready_o), 64'(!wr_valid_o || wr_ready_i));
        if (wr_valid_o) begin
          beat_t cur;
          cur = {wr_addr_o, wr_be_o, wr_data_o, wr_probe_o};
          if (hold_pend)
            check(cur == last, "R8", "held beat", 64'(cur[DATA_W+LANES:0]), 64'(last[DATA_W+LANES:0]));
          if (wr_ready_i) begin
            beats++;
            if (exp_q.size() == 0) begin
              check(0, "R4", "extra beat", 64'(beats), 64'(sent));
            end else begin
              beat_t e;
              e = exp_q.pop_front();
              check(wr_addr_o == e.addr, "R7", "addr", 64'(wr_addr_o), 64'(e.addr));
              check(wr_be_o == e.be, e.probe ? "R5" : "R2/R3", "be", 64'(wr_be_o), 64'(e.be));
              check(wr_data_o == e.data, "R6", "data", 64'(wr_data_o), 64'(e.data));
              check(wr_probe_o == e.probe, "R5", "probe", 64'(wr_probe_o), 64'(e.probe));
              for (int j = 0; j < LANES; j++)
                if (wr_be_o[LANES-1-j])
                  dut_mem[(int'(wr_addr_o) & (MEM_B-4)) + j] = wr_data_o[DATA_W-1-8*j -: 8];
            end
          end
          hold_pend = !wr_ready_i;
          last = cur;
        end else begin
          hold_pend = 0;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] pats [4];
    pats[0] = 32'h11223344; pats[1] = 32'hA1B2C3D4;
    pats[2] = 32'hFFFFFFFF; pats[3] = 32'h5A0F96E1;
    for (int i = 0; i < MEM_B; i++) begin
      ref_mem[i] = 8'hC3;
      dut_mem[i] = 8'hC3;
    end
    #(CLK_PERIOD * 2 + 2);
    // R1
    check(wr_valid_o == 0, "R1", "valid in reset", 64'(wr_valid_o), 0);
    check(req_ready_o == 1, "R1", "ready in reset", 64'(req_ready_o), 1);
    @(negedge clk) rst_ni = 1;
    @(negedge clk);
    check(wr_valid_o == 0, "R1", "valid after reset", 64'(wr_valid_o), 0);

    // all op/offset pairs, several words, with back-pressure
    for (int p = 0; p < 4; p++)
      for (int op = 0; op < 2; op++)
        for (int k = 0; k < 4; k++)
          send(op[0], ADDR_W'(((p * 8 + op * 4 + k) % 16) * 4 + k), pats[p]);

    // back-to-back with full throughput
    full_ready = 1;
    for (int k = 0; k < 4; k++) begin
      send(1'b0, ADDR_W'(40 + k), 32'hDEADBEEF);
      send(1'b1, ADDR_W'(52 + k), 32'h0BADF00D);
    end
    full_ready = 0;
    // three-byte cases: one beat each (R4)
    send(1'b0, 32'h0000_0021, 32'h01020304);
    send(1'b1, 32'h0000_0037, 32'hF0E0D0C0);

    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    check(beats == sent, "R4", "beats per request", 64'(beats), 64'(sent));
    for (int i = 0; i < MEM_B; i++)
      check(dut_mem[i] == ref_mem[i], "R6", "memory byte", 64'(dut_mem[i]), 64'(ref_mem[i]));
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule